// File: doc/BRIEF.md
# Link Self-Test Frame Checker

This block watches a stream of received payload frames while the serial link runs its built-in self test. It keeps a saturating count of frames that arrived with errors, which software can read, and it drives a single PASS status line that a tester can watch from outside. While checking, PASS sits high and drops for one short pulse per errored frame. Back-to-back errored frames queue up so that each one gets its own separate pulse. When the test ends, PASS shows the overall verdict for a short window and then returns to its idle low level. The error count stays readable until the next test session starts.

Self test is enabled when either the dedicated enable pin or the enable register bit is high. Checking begins once the receiver also reports lock. The block also picks the test clock source. It reads a 2-bit select either from a pin pair or from a register field, as chosen by a control bit. The two inputs use different code tables, and the block maps both onto one output code. Frames enter on a valid strobe that carries an error flag. The input has no back-pressure: every strobed frame is taken in the cycle it is presented, so the stream has no ready signal.

Top module: `lbist_monitor`

## Requirements
- R1: After reset, PASS is 0, the error count is 0 and the clock select output is 00.
- R2: Self test is enabled when the enable pin or the enable register bit is high. PASS rises to 1 one cycle after a clock edge that samples both enable and lock high. Before that, PASS stays 0.
- R3: A frame is counted only when the valid strobe and the error flag are both high in a checking cycle. Each such frame adds exactly one to the count. A valid frame without the error flag, or an error flag without the valid strobe, changes nothing.
- R4: The error count saturates at 2^CNT_W-1 (255 with an 8-bit count) and does not wrap.
- R5: A rising edge of the combined enable clears the error count to 0.
- R6: Each counted frame drives PASS low for exactly PULSE_CYC cycles. The pulse starts in the cycle after the frame, unless an earlier pulse is still running.
- R7: Errored frames that arrive while a pulse is running are queued. Each one gets its own low pulse, and queued pulses are separated by exactly one high cycle.
- R8: When enable falls during a session, PASS shows the verdict for RES_CYC cycles: 1 if the count is 0, and 0 otherwise. After that, PASS returns to 0.
- R9: After a session ends, the error count holds its value until the next rising enable edge or reset.
- R10: If lock drops while checking, PASS goes to 0 in the next cycle, frames are ignored and queued pulses are discarded. Checking resumes, with PASS at 1, after lock returns.
- R11: The clock select output uses these codes: 00 external clock, 01 about 12.5 MHz, 10 about 25 MHz, 11 about 50 MHz. While enable is low, the output is forced to 00.
- R12: When the source bit is 1, the pin pair is decoded as 00 external, 01 about 25 MHz, 10 about 50 MHz, 11 about 12.5 MHz.
- R13: When the source bit is 0, the register field is decoded as 00 external, 01 about 50 MHz, 10 about 25 MHz, 11 about 12.5 MHz.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bist_en_pin_i | input | 1 | Self-test enable from the pin |
| bist_en_reg_i | input | 1 | Self-test enable from the register bit |
| lock_i | input | 1 | Receiver lock |
| frm_valid_i | input | 1 | Frame strobe; frames are always accepted |
| frm_err_i | input | 1 | Frame contained one or more errors |
| sel_from_pin_i | input | 1 | 1: decode the pin pair; 0: decode the register field |
| sel_pin_i | input | 2 | Clock select from the pin pair |
| sel_reg_i | input | 2 | Clock select from the register field |
| pass_o | output | 1 | Real-time status and end-of-test verdict |
| err_cnt_o | output | CNT_W | Saturating count of errored frames |
| osc_sel_o | output | 2 | Unified clock source code |

## Verification
The bench builds the block with CNT_W=8, PULSE_CYC=3, RES_CYC=4 and PEND_W=4. With a three-cycle pulse, the length of each pulse and the one-cycle gap between queued pulses can be measured exactly within a few cycles. The 8-bit count reaches saturation after a 300-frame burst. That same burst also fills the 4-bit pending queue, which exercises saturation of both counters. The four-cycle verdict window is short enough to be checked sample by sample, for both a clean session and a failing session.

// File: rtl/lbist_pkg.sv
package lbist_pkg;

  typedef enum logic [1:0] {
    OSC_EXT  = 2'b00,
    OSC_12M5 = 2'b01,
    OSC_25M  = 2'b10,
    OSC_50M  = 2'b11
  } osc_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_CHECK,
    ST_RESULT
  } mon_st_e;

  // pin pair table: 01 -> 25 MHz, 10 -> 50 MHz
  function automatic osc_e decode_pin(input logic [1:0] code);
    case (code)
      2'b00:   return OSC_EXT;
      2'b01:   return OSC_25M;
      2'b10:   return OSC_50M;
      default: return OSC_12M5;
    endcase
  endfunction

  // register table: 01 -> 50 MHz, 10 -> 25 MHz
  function automatic osc_e decode_reg(input logic [1:0] code);
    case (code)
      2'b00:   return OSC_EXT;
      2'b01:   return OSC_50M;
      2'b10:   return OSC_25M;
      default: return OSC_12M5;
    endcase
  endfunction

endpackage

// File: rtl/lbist_osc_decode.sv
module lbist_osc_decode
  import lbist_pkg::*;
(
  input  logic       en_i,
  input  logic       from_pin_i,
  input  logic [1:0] pin_code_i,
  input  logic [1:0] reg_code_i,
  output logic [1:0] osc_sel_o
);

  osc_e sel;

  always_comb begin
    if (!en_i)           sel = OSC_EXT;
    else if (from_pin_i) sel = decode_pin(pin_code_i);
    else                 sel = decode_reg(reg_code_i);
  end

  assign osc_sel_o = sel;

endmodule

// File: rtl/lbist_err_counter.sv
module lbist_err_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           cnt_q <= '0;
    else if (clr_i)                       cnt_q <= '0;
    else if (inc_i && cnt_q != CNT_MAX)   cnt_q <= cnt_q + CNT_ONE;
  end

  assign cnt_o = cnt_q;

  p_count_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !clr_i && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + CNT_ONE));

  p_no_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX && !clr_i) |=> (cnt_q == CNT_MAX));

endmodule

// File: rtl/lbist_pulse_gen.sv
module lbist_pulse_gen #(
  parameter int PULSE_CYC = 3,
  parameter int PEND_W    = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic req_i,
  output logic low_o
);

  localparam int LW = $clog2(PULSE_CYC + 1);
  localparam logic [LW-1:0]     LEFT_INIT = LW'(PULSE_CYC);
  localparam logic [LW-1:0]     LEFT_ONE  = LW'(1);
  localparam logic [PEND_W-1:0] PEND_MAX  = '1;
  localparam logic [PEND_W-1:0] PEND_ONE  = PEND_W'(1);

  logic [LW-1:0]     left_q;
  logic [PEND_W-1:0] pend_q;
  logic              start;

  // a new pulse may begin the cycle after the previous one ends
  assign start = (left_q == '0) && (req_i || pend_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
      pend_q <= '0;
    end else if (clr_i) begin
      left_q <= '0;
      pend_q <= '0;
    end else begin
      if (left_q != '0) left_q <= left_q - LEFT_ONE;
      else if (start)   left_q <= LEFT_INIT;

      if (req_i && !start) begin
        if (pend_q != PEND_MAX) pend_q <= pend_q + PEND_ONE;
      end else if (!req_i && start) begin
        pend_q <= pend_q - PEND_ONE;
      end
    end
  end

  assign low_o = (left_q != '0);

  p_pulse_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (left_q > LEFT_ONE && !clr_i) |=> low_o);

  p_queue_drains_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q != '0 && !low_o && !clr_i) |=> low_o);

endmodule

// File: rtl/lbist_monitor.sv
module lbist_monitor
  import lbist_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int PULSE_CYC = 3,
  parameter int RES_CYC   = 4,
  parameter int PEND_W    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bist_en_pin_i,
  input  logic             bist_en_reg_i,
  input  logic             lock_i,
  input  logic             frm_valid_i,
  input  logic             frm_err_i,
  input  logic             sel_from_pin_i,
  input  logic [1:0]       sel_pin_i,
  input  logic [1:0]       sel_reg_i,
  output logic             pass_o,
  output logic [CNT_W-1:0] err_cnt_o,
  output logic [1:0]       osc_sel_o
);

  localparam int RES_W = $clog2(RES_CYC + 1);
  localparam logic [RES_W-1:0] RES_INIT = RES_W'(RES_CYC);
  localparam logic [RES_W-1:0] RES_ONE  = RES_W'(1);

  logic             en, en_q, en_rise;
  mon_st_e          st_q, st_d;
  logic [RES_W-1:0] res_q, res_d;
  logic             take, pulse_clr, pulse_low;

  assign en      = bist_en_pin_i | bist_en_reg_i;
  assign en_rise = en & ~en_q;

  always_comb begin
    st_d  = st_q;
    res_d = res_q;
    if (en_rise) begin
      st_d  = ST_WAIT;
      res_d = '0;
    end else begin
      unique case (st_q)
        ST_IDLE: st_d = ST_IDLE;
        ST_WAIT: begin
          if (!en) begin
            st_d  = ST_RESULT;
            res_d = RES_INIT;
          end else if (lock_i) begin
            st_d = ST_CHECK;
          end
        end
        ST_CHECK: begin
          if (!en) begin
            st_d  = ST_RESULT;
            res_d = RES_INIT;
          end else if (!lock_i) begin
            st_d = ST_WAIT;
          end
        end
        ST_RESULT: begin
          if (res_q <= RES_ONE) st_d = ST_IDLE;
          else                  res_d = res_q - RES_ONE;
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      st_q  <= ST_IDLE;
      res_q <= '0;
    end else begin
      en_q  <= en;
      st_q  <= st_d;
      res_q <= res_d;
    end
  end

  assign take      = (st_q == ST_CHECK) && en && lock_i && frm_valid_i && frm_err_i;
  assign pulse_clr = en_rise || (st_q != ST_CHECK);

  lbist_err_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (en_rise),
    .inc_i (take),
    .cnt_o (err_cnt_o)
  );

  lbist_pulse_gen #(.PULSE_CYC(PULSE_CYC), .PEND_W(PEND_W)) u_pulse (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (pulse_clr),
    .req_i (take),
    .low_o (pulse_low)
  );

  lbist_osc_decode u_osc (
    .en_i       (en),
    .from_pin_i (sel_from_pin_i),
    .pin_code_i (sel_pin_i),
    .reg_code_i (sel_reg_i),
    .osc_sel_o  (osc_sel_o)
  );

  always_comb begin
    unique case (st_q)
      ST_CHECK:  pass_o = ~pulse_low;
      ST_RESULT: pass_o = (err_cnt_o == '0);
      default:   pass_o = 1'b0;
    endcase
  end

  p_check_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_CHECK) |-> $past(en && lock_i));

  p_clear_on_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    en_rise |=> (err_cnt_o == '0));

  p_verdict_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_WAIT || st_q == ST_CHECK) && !en) |=> (st_q == ST_RESULT));

  p_count_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_IDLE || st_q == ST_RESULT) && !en_rise) |=> $stable(err_cnt_o));

  p_lock_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_CHECK && en && !lock_i) |=> !pass_o);

  p_sel_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (osc_sel_o == 2'b00));

  p_pin_map_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (en && sel_from_pin_i && sel_pin_i == 2'b10) |-> (osc_sel_o == 2'b11));

  p_reg_map_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !sel_from_pin_i && sel_reg_i == 2'b01) |-> (osc_sel_o == 2'b11));

endmodule

// File: tb/lbist_monitor_bench.sv
`timescale 1ns/1ps
module lbist_monitor_bench;

  localparam int CNT_W = 8;
  localparam int PC    = 3;
  localparam int RC    = 4;
  localparam int PW    = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_pin = 1'b0, en_reg = 1'b0, lock = 1'b0;
  logic fv = 1'b0, fe = 1'b0, from_pin = 1'b0;
  logic [1:0] pin_code = 2'b00, reg_code = 2'b00;
  logic pass;
  logic [CNT_W-1:0] cnt;
  logic [1:0] osc;

  int n_chk = 0, n_fail = 0, exp_cnt = 0;
  int falls = 0, last_low = 0, last_gap = 0, low_run = 0, high_run = 0;
  logic prev_pass = 1'b0;

  always #2.5 clk = ~clk;

  lbist_monitor #(.CNT_W(CNT_W), .PULSE_CYC(PC), .RES_CYC(RC), .PEND_W(PW)) u_lbist_monitor (
    .clk(clk), .rst_n(rst_n), .bist_en_pin_i(en_pin), .bist_en_reg_i(en_reg),
    .lock_i(lock), .frm_valid_i(fv), .frm_err_i(fe), .sel_from_pin_i(from_pin),
    .sel_pin_i(pin_code), .sel_reg_i(reg_code), .pass_o(pass), .err_cnt_o(cnt),
    .osc_sel_o(osc)
  );

  // pulse monitor on PASS, sampled at the falling clock edge
  always @(negedge clk) begin
    if (!pass) begin
      if (prev_pass) begin
        falls++;
        last_gap = high_run;
        low_run = 1;
      end else begin
        low_run++;
      end
    end else begin
      if (!prev_pass) begin
        last_low = low_run;
        high_run = 1;
      end else begin
        high_run++;
      end
    end
    prev_pass = pass;
  end

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    repeat (n) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    step(3);
    chk(pass == 1'b0, "R1 pass", int'(pass), 0);
    chk(cnt == 0, "R1 count", int'(cnt), 0);
    chk(osc == 2'b00, "R1 select", int'(osc), 0);
    rst_n = 1'b1;
    step(2);
  endtask

  task automatic t_osc_select();
    int pin_exp[4] = '{0, 2, 3, 1};
    int reg_exp[4] = '{0, 3, 2, 1};
    from_pin = 1'b1;
    pin_code = 2'b10;
    #1;
    chk(osc == 2'b00, "R11 forced external while disabled", int'(osc), 0);
    lock = 1'b0;
    en_reg = 1'b1;
    step();
    for (int i = 0; i < 4; i++) begin
      from_pin = 1'b1;
      pin_code = 2'(i);
      reg_code = 2'(3 - i);
      #1;
      chk(int'(osc) == pin_exp[i], "R12 pin map", int'(osc), pin_exp[i]);
      from_pin = 1'b0;
      reg_code = 2'(i);
      pin_code = 2'(3 - i);
      #1;
      chk(int'(osc) == reg_exp[i], "R13 register map", int'(osc), reg_exp[i]);
    end
    en_reg = 1'b0;
    step(RC + 3);
  endtask

  task automatic t_start_no_lock();
    lock = 1'b0;
    en_reg = 1'b1;
    step(3);
    chk(pass == 1'b0, "R2 no lock yet", int'(pass), 0);
    lock = 1'b1;
    step();
    chk(pass == 1'b1, "R2 checking starts", int'(pass), 1);
    exp_cnt = 0;
  endtask

  task automatic t_single_error();
    int f0 = falls;
    fv = 1'b1;
    fe = 1'b1;
    step();
    fv = 1'b0;
    fe = 1'b0;
    exp_cnt++;
    chk(pass == 1'b0, "R6 pulse starts next cycle", int'(pass), 0);
    chk(int'(cnt) == exp_cnt, "R3 count one frame", int'(cnt), exp_cnt);
    step(PC + 2);
    chk(falls - f0 == 1, "R6 one pulse", falls - f0, 1);
    chk(last_low == PC, "R6 pulse length", last_low, PC);
    chk(pass == 1'b1, "R6 back high", int'(pass), 1);
  endtask

  task automatic t_clean_frames();
    int f0 = falls;
    fv = 1'b1;
    fe = 1'b0;
    step(4);
    fv = 1'b0;
    fe = 1'b1;
    step(4);
    fe = 1'b0;
    step(2);
    chk(int'(cnt) == exp_cnt, "R3 unflagged frames ignored", int'(cnt), exp_cnt);
    chk(falls == f0, "R3 no pulse", falls - f0, 0);
  endtask

  task automatic t_back_to_back();
    int f0 = falls;
    fv = 1'b1;
    fe = 1'b1;
    step(3);
    fv = 1'b0;
    fe = 1'b0;
    exp_cnt += 3;
    step(3 * (PC + 1) + 2);
    chk(falls - f0 == 3, "R7 distinct pulses", falls - f0, 3);
    chk(last_low == PC, "R7 queued pulse length", last_low, PC);
    chk(last_gap == 1, "R7 single high cycle between", last_gap, 1);
    chk(int'(cnt) == exp_cnt, "R3 burst counted", int'(cnt), exp_cnt);
  endtask

  task automatic t_lock_loss();
    int f0;
    fv = 1'b1;
    fe = 1'b1;
    step();
    exp_cnt++;
    lock = 1'b0;
    fv = 1'b0;
    fe = 1'b0;
    step();
    chk(pass == 1'b0, "R10 pass low on lock loss", int'(pass), 0);
    f0 = falls;
    fv = 1'b1;
    fe = 1'b1;
    step(3);
    fv = 1'b0;
    fe = 1'b0;
    chk(int'(cnt) == exp_cnt, "R10 frames ignored unlocked", int'(cnt), exp_cnt);
    lock = 1'b1;
    step();
    chk(pass == 1'b1, "R10 resumes with queue flushed", int'(pass), 1);
    step(PC + 2);
    chk(falls == f0, "R10 no stale pulse", falls - f0, 0);
  endtask

  task automatic t_end_fail();
    en_reg = 1'b0;
    for (int i = 0; i < RC; i++) begin
      step();
      chk(pass == 1'b0, "R8 failing verdict", int'(pass), 0);
    end
    step();
    chk(pass == 1'b0, "R8 back to idle", int'(pass), 0);
    step(10);
    chk(int'(cnt) == exp_cnt, "R9 count held", int'(cnt), exp_cnt);
  endtask

  task automatic t_pin_clean_session();
    lock = 1'b1;
    en_pin = 1'b1;
    step();
    chk(cnt == 0, "R5 cleared on new session", int'(cnt), 0);
    step();
    chk(pass == 1'b1, "R2 pin enable", int'(pass), 1);
    step(5);
    en_pin = 1'b0;
    for (int i = 0; i < RC; i++) begin
      step();
      chk(pass == 1'b1, "R8 passing verdict", int'(pass), 1);
    end
    step();
    chk(pass == 1'b0, "R8 verdict not held", int'(pass), 0);
  endtask

  task automatic t_saturate();
    en_reg = 1'b1;
    lock = 1'b1;
    step(2);
    fv = 1'b1;
    fe = 1'b1;
    step(300);
    fv = 1'b0;
    fe = 1'b0;
    chk(cnt == 8'hFF, "R4 saturates", int'(cnt), 255);
    step(20 * (PC + 1));
    chk(cnt == 8'hFF, "R4 stays saturated", int'(cnt), 255);
    chk(pass == 1'b1, "R7 queue drained", int'(pass), 1);
    en_reg = 1'b0;
    step();
    chk(pass == 1'b0, "R8 verdict after saturation", int'(pass), 0);
    step(RC + 2);
  endtask

  initial begin
    t_reset();
    t_osc_select();
    t_start_no_lock();
    t_single_error();
    t_clean_frames();
    t_back_to_back();
    t_lock_loss();
    t_end_fail();
    t_pin_clean_session();
    t_saturate();
    finish_run();
  end

endmodule